// File: doc/BRIEF.md
# Single-Read Bus Requester

This block is the requesting side of an APB link, limited to single read transfers. A local client gives it an address and a one-cycle start strobe. The block then runs the bus through three phases: idle, a setup cycle with select raised, and an access cycle with enable raised. It stays in access for as long as the responder holds ready low.

The read value is registered only on the completion cycle. That is the cycle where select, enable and ready are all high and the direction line reads low. On every other cycle the bus data input is treated as don't-care. One cycle after completion, the captured word appears on the response output together with a one-cycle done strobe.

The write data output is tied to zero. The direction output always indicates a read.

Top module: `apb_read_requester`

## Requirements
- R1: While `rstN` is low at a clock edge, the block returns to idle. After that edge, `busSel`, `busEnable`, `busy` and `rspValid` are 0 and `busAddr` and `rspData` are 0.
- R2: If `reqStart` is high at an edge while idle, the next cycle is setup: `busSel`=1, `busEnable`=0, `busAddr` equals the sampled `reqAddr`.
- R3: A setup cycle is always followed by an access cycle with `busSel`=1 and `busEnable`=1.
- R4: `busAddr` holds its setup value unchanged until the transfer ends. `busWrite` is 0 and `busWdata` is 0 on every cycle.
- R5: In access with `busReady` low, the block stays in access on the next cycle with all bus outputs unchanged. Any number of such wait cycles is allowed.
- R6: After an access cycle with `busReady` high, the next cycle is idle with `busSel`=0 and `busEnable`=0.
- R7: `rspValid` is high for exactly the one cycle after the completion edge. In that cycle `rspData` equals the `busRdata` value present on the completion edge.
- R8: `busRdata` is never registered outside the completion edge. This holds in setup, during waits, and in idle even when `busReady` is high. `rspData` keeps the last captured word until the next completion.
- R9: A `reqStart` that arrives while a transfer is in progress is ignored: the address and the phase sequence are not affected.
- R10: `busy` is high in every setup and access cycle and low in idle. A start is accepted in the same cycle that `rspValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqStart | input | 1 | Start strobe from the local client |
| reqAddr | input | ADDR_W | Address of the read to perform |
| busy | output | 1 | A transfer is in progress; a new start is ignored |
| rspValid | output | 1 | One-cycle done strobe |
| rspData | output | DATA_W | Captured read word |
| busSel | output | 1 | Responder select |
| busEnable | output | 1 | Access-phase enable |
| busWrite | output | 1 | Direction, always 0 (read) |
| busAddr | output | ADDR_W | Bus address, held through the transfer |
| busWdata | output | DATA_W | Write data, tied to 0 |
| busReady | input | 1 | Responder ready |
| busRdata | input | DATA_W | Responder read data |

## Verification
Several properties hold locally across adjacent cycles, and assertions check them on every cycle:
- setup always leads to access;
- an access cycle without ready stays in access;
- completion returns to idle;
- the address is held once selected, and a start during busy leaves it alone;
- the done strobe never lasts two cycles;
- the response word never changes without the done strobe.

Some properties need the bench's cycle-by-cycle reference and its scripted responder to be shown:
- the returned word is exactly the one present on the completion edge, not one offered during waits or on an idle cycle with ready high;
- wait counts of zero, several and many cycles work;
- a start is accepted on the done cycle;
- a reset in the middle of a wait abandons the transfer.

// File: rtl/apb_rd_pkg.sv
package apb_rd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_e;

  // Strobes from the phase controller to the datapath
  typedef struct packed {
    logic loadAddr;  // latch the request address (start accepted)
    logic capture;   // qualified completion edge: register read data
  } strobe_t;

endpackage

// File: rtl/apb_rd_ctrl.sv
module apb_rd_ctrl
  import apb_rd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqStart,
  input  logic    busReady,
  input  logic    busWrite,
  output strobe_t stb,
  output logic    busSel,
  output logic    busEnable,
  output logic    busy
);

  phase_e phaseQ, phaseD;

  always_comb begin
    phaseD = phaseQ;
    unique case (phaseQ)
      PH_IDLE:   if (reqStart) phaseD = PH_SETUP;
      PH_SETUP:  phaseD = PH_ACCESS;
      PH_ACCESS: if (busReady) phaseD = PH_IDLE;
      default:   phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseD;
  end

  assign busSel    = (phaseQ != PH_IDLE);
  assign busEnable = (phaseQ == PH_ACCESS);
  assign busy      = busSel;

  always_comb begin
    stb          = '0;
    stb.loadAddr = (phaseQ == PH_IDLE) && reqStart;
    stb.capture  = busSel && busEnable && busReady && !busWrite;
  end

  AST_SETUP_TO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busEnable) |=> (busSel && busEnable)); // R3

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busEnable && !busReady) |=> (busSel && busEnable)); // R5

  AST_COMPLETE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (busEnable && busReady) |=> (!busSel && !busEnable)); // R6

endmodule

// File: rtl/apb_rd_datapath.sv
module apb_rd_datapath
  import apb_rd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      doneQ <= 1'b0;
    end else begin
      if (stb.loadAddr) addrQ <= reqAddr;
      if (stb.capture)  dataQ <= busRdata;
      doneQ <= stb.capture;
    end
  end

  assign busAddr  = addrQ;
  assign busWrite = 1'b0;
  assign busWdata = '0;
  assign rspData  = dataQ;
  assign rspValid = doneQ;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R7

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> $stable(rspData)); // R8

endmodule

// File: rtl/apb_read_requester.sv
module apb_read_requester
  import apb_rd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              busy,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              busSel,
  output logic              busEnable,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busReady,
  input  logic [DATA_W-1:0] busRdata
);

  strobe_t stb;

  apb_rd_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqStart  (reqStart),
    .busReady  (busReady),
    .busWrite  (busWrite),
    .stb       (stb),
    .busSel    (busSel),
    .busEnable (busEnable),
    .busy      (busy)
  );

  apb_rd_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .busWdata (busWdata),
    .rspData  (rspData),
    .rspValid (rspValid)
  );

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && $past(busSel)) |-> $stable(busAddr)); // R4

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqStart) |=> $stable(busAddr)); // R9

endmodule

// File: tb/sim_apb_read_requester.sv
module sim_apb_read_requester;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqStart = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              busy, rspValid, busSel, busEnable, busWrite;
  logic [DATA_W-1:0] rspData, busWdata;
  logic [ADDR_W-1:0] busAddr;
  logic              busReady = 1'b0;
  logic [DATA_W-1:0] busRdata = '0;

  always #4 clk = ~clk;  // 125 MHz

  apb_read_requester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqAddr(reqAddr),
    .busy(busy), .rspValid(rspValid), .rspData(rspData),
    .busSel(busSel), .busEnable(busEnable), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
               req, what, act, exp, cyc);
    end
  endtask

  // Scripted responder: ready is held low for planWaits access cycles, then
  // planData is offered with ready. Outside access, garbage and toggling ready.
  int                planWaits = 0;
  logic [DATA_W-1:0] planData  = '0;
  int                waitCnt   = 0;

  always @(negedge clk) begin
    if (busSel && busEnable) begin
      if (waitCnt < planWaits) begin
        busReady <= 1'b0;
        busRdata <= 32'hBAD0_0000 | 32'(cyc);
        waitCnt++;
      end else begin
        busReady <= 1'b1;
        busRdata <= planData;
      end
    end else begin
      waitCnt  = 0;
      busReady <= cyc[0];
      busRdata <= 32'hFEE0_0000 | 32'(cyc);
    end
  end

  // Behavioural reference: 0 idle, 1 setup, 2 access
  int                mPh = 0;
  logic [ADDR_W-1:0] mAddr = '0;
  logic [DATA_W-1:0] mData = '0;
  logic              mValid = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mPh = 0; mAddr = '0; mData = '0; mValid = 1'b0;
    end else begin
      mValid = 1'b0;
      if (mPh == 0) begin
        if (reqStart) begin mPh = 1; mAddr = reqAddr; end
      end else if (mPh == 1) begin
        mPh = 2;
      end else if (busReady) begin
        mData = busRdata; mValid = 1'b1; mPh = 0;
      end
    end
  end

  always @(posedge clk) begin
    #3;
    chk("R2/R6", "busSel", 64'(busSel), 64'(mPh != 0));
    chk("R3/R5", "busEnable", 64'(busEnable), 64'(mPh == 2));
    chk("R10", "busy", 64'(busy), 64'(mPh != 0));
    chk("R4", "busWrite", 64'(busWrite), 64'd0);
    chk("R4", "busWdata", 64'(busWdata), 64'd0);
    if (mPh != 0) chk("R4/R9", "busAddr", 64'(busAddr), 64'(mAddr));
    chk("R7", "rspValid", 64'(rspValid), 64'(mValid));
    chk("R8", "rspData", 64'(rspData), 64'(mData));
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic doRead(input logic [ADDR_W-1:0] a, input int waits,
                        input logic [DATA_W-1:0] d);
    @(negedge clk);
    planWaits = waits; planData = d;
    reqStart = 1'b1; reqAddr = a;
    @(negedge clk);
    reqStart = 1'b0;
    for (int i = 0; i < 200 && !rspValid; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busSel", 64'(busSel), 64'd0);
    chk("R1", "busEnable", 64'(busEnable), 64'd0);
    chk("R1", "rspValid", 64'(rspValid), 64'd0);
    chk("R1", "rspData", 64'(rspData), 64'd0);
    rstN = 1'b1;

    doRead(12'h010, 0, 32'h1234_5678);  // R7 zero wait
    doRead(12'h3A4, 1, 32'hCAFE_0001);  // R5 one wait
    doRead(12'hFFF, 4, 32'h0000_0000);  // R8 waits with garbage
    doRead(12'h000, 9, 32'hFFFF_FFFF);

    // R9: start held high and re-driven with another address while busy
    @(negedge clk);
    planWaits = 3; planData = 32'hA5A5_5A5A;
    reqStart = 1'b1; reqAddr = 12'h555;
    @(negedge clk); reqAddr = 12'hAAA;
    @(negedge clk); reqAddr = 12'h123;
    @(negedge clk); reqStart = 1'b0;
    for (int i = 0; i < 50 && !rspValid; i++) @(negedge clk);

    // R10: start accepted on the done cycle (back to back)
    planWaits = 0; planData = 32'h0BAC_0B0C;
    reqStart = 1'b1; reqAddr = 12'h0F0;
    @(negedge clk); reqStart = 1'b0;
    for (int i = 0; i < 50 && !rspValid; i++) @(negedge clk);

    // R1: reset in the middle of a waiting access
    @(negedge clk);
    planWaits = 6; planData = 32'hDEAD_BEEF;
    reqStart = 1'b1; reqAddr = 12'h777;
    @(negedge clk); reqStart = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    chk("R1", "busSel after mid reset", 64'(busSel), 64'd0);
    chk("R1", "rspData after mid reset", 64'(rspData), 64'd0);

    doRead(12'h2C8, 2, 32'h7654_3210);
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule